// File: doc/BRIEF.md
# Bus Break Condition Matcher

This block watches a processor's bus and instruction stream every clock and raises a break request when a set of programmed conditions is met. It is meant to sit next to a debug controller. That controller programs comparison values, masks and qualifiers through a simple write-only register port, and it reacts to the break pulse by halting the core.

There are three condition channels, and each supports a different fixed set of condition types. Channel 1 is the richest. It can compare an address or program counter under a mask, compare data on the active byte lanes, check the access size, apply a read/write qualifier and a bus-view qualifier, and require an occurrence count. Channel 2 offers only the address or PC compare and the read/write and bus-view qualifiers. Channel 3 matches only two events: an internal-I/O access and execution of a TLB-load instruction.

Within a channel, every enabled sub-condition must hold at the same time, and a disabled sub-condition is treated as true. A match is reported one clock after the cycle that caused it. The report takes three forms: a one-cycle break pulse, a one-cycle per-channel hit vector, and a sticky per-channel status that software clears by writing ones.

Top module: `bus_break_matcher`

## Requirements
- R1: After reset, `brk_pulse`, `brk_hit` and `brk_status` are all zero, and every configuration register is zero, so every channel is disabled.
- R2: Register map by `cfg_addr`: 0 = ch1 address value, 1 = ch1 address ignore-mask (a bit set to 1 is not compared), 4 = ch1 control, 6 = ch2 address value, 7 = ch2 address ignore-mask, 8 = ch2 control. In both control registers, bit 0 enables the address compare and bit 1 selects `pc_value` qualified by `pc_valid` instead of `bus_addr` qualified by `bus_valid`. A match in cycle t appears on `brk_hit` and `brk_pulse` in cycle t+1, for one cycle.
- R3: Register 2 holds the ch1 data value and register 3 its ignore-mask. Bit 2 of the ch1 control enables the data compare. Only the byte lanes the access uses are compared, in big-endian order: byte lane k of the bus is bits [31-8k:24-8k]. A byte access (size code 0) uses lane `bus_addr[1:0]`. A word access (code 1) uses lanes 0–1 when `bus_addr[1]` is 0 and lanes 2–3 when it is 1. A longword access (code 2) uses all lanes. Bit 3 of the ch1 control enables a check that `bus_size` equals ch1 control bits [5:4].
- R4: Control bits [7:6] select the read/write qualifier: 1 matches reads only (`bus_write`=0), 2 matches writes only, and 0 or 3 means either and does not count as an enabled sub-condition.
- R5: Control bit 10 enables the bus-view qualifier, and bits [9:8] select the view. View 0 matches any CPU cycle (`bus_dma`=0), including cache hits. View 1 matches CPU data cycles only (`bus_dma`=0 and `bus_fetch`=0). View 2 matches DMA cycles and CPU cycles that miss the cache (`bus_cache_hit`=0). View 3 matches any bus cycle.
- R6: When ch1 control bit 11 is set, ch1 fires only on the N-th satisfaction of its combined condition, where N is the value in register 5. The occurrence counter then restarts from zero. A value of 0 or 1 in register 5 fires on every satisfaction.
- R7: Channel 2 has no data, size or count conditions. Its hits do not depend on `bus_data` or `bus_size`, or on the contents of registers 2, 3 or 5.
- R8: Register 9 controls channel 3: bit 0 requires `io_access` and bit 1 requires `tlb_load`. Channel 3 fires when it is enabled and every selected event is present in the cycle.
- R9: `brk_status[i]` sets on each hit of channel i and holds until a write to register 10 with bit i set. A hit in the same cycle as the clear leaves the bit set. Writing register 5, or clearing status bit 0, restarts the ch1 occurrence counter from zero.
- R10: Bit 12 of a control register enables its channel. A disabled channel never fires. An enabled channel with no sub-condition enabled also never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A bus cycle is present |
| bus_addr | input | AW | Bus cycle address |
| bus_data | input | DW | Bus cycle data |
| bus_size | input | 2 | Access size: 0 byte, 1 word, 2 longword |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_fetch | input | 1 | Cycle is an instruction fetch |
| bus_dma | input | 1 | Cycle is driven by DMA |
| bus_cache_hit | input | 1 | Cycle hit the cache |
| pc_valid | input | 1 | An instruction executes this cycle |
| pc_value | input | AW | Program counter of that instruction |
| io_access | input | 1 | Internal-I/O access this cycle |
| tlb_load | input | 1 | TLB-load instruction executes this cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register index |
| cfg_wdata | input | RW | Configuration write data (RW = max(AW, DW)) |
| brk_pulse | output | 1 | One-cycle break request |
| brk_hit | output | 3 | One-cycle per-channel hit |
| brk_status | output | 3 | Sticky per-channel hit flags |

## Verification
The bench builds the block with its defaults: AW = DW = 32 and an 8-bit occurrence counter. With these values every byte-lane position and both word halves of the big-endian data compare can be reached. A count limit of a few units lets the wrap and restart of the counter happen many times inside one run. Directed steps cover lane selection, the qualifier encodings, the count restart and the clear-versus-set collision. Random configurations, drawn with addresses from a small pool, then exercise channel combinations at a high hit rate.

// File: rtl/bus_break_matcher.sv
module bus_break_matcher #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 8,
  localparam int RW = (AW > DW) ? AW : DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic [1:0]    bus_size,
  input  logic          bus_write,
  input  logic          bus_fetch,
  input  logic          bus_dma,
  input  logic          bus_cache_hit,
  input  logic          pc_valid,
  input  logic [AW-1:0] pc_value,
  input  logic          io_access,
  input  logic          tlb_load,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_addr,
  input  logic [RW-1:0] cfg_wdata,
  output logic          brk_pulse,
  output logic [2:0]    brk_hit,
  output logic [2:0]    brk_status
);
  localparam int NL = DW / 8;
  localparam int LB = (NL > 1) ? $clog2(NL) : 1;

  logic [AW-1:0] a1_val, a1_msk, a2_val, a2_msk;
  logic [DW-1:0] d1_val, d1_msk;
  logic [12:0]   c1, c2, c3;
  logic [CW-1:0] cnt_lim, cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a1_val <= '0; a1_msk <= '0; a2_val <= '0; a2_msk <= '0;
      d1_val <= '0; d1_msk <= '0;
      c1 <= '0; c2 <= '0; c3 <= '0; cnt_lim <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        4'd0: a1_val  <= cfg_wdata[AW-1:0];
        4'd1: a1_msk  <= cfg_wdata[AW-1:0];
        4'd2: d1_val  <= cfg_wdata[DW-1:0];
        4'd3: d1_msk  <= cfg_wdata[DW-1:0];
        4'd4: c1      <= cfg_wdata[12:0];
        4'd5: cnt_lim <= cfg_wdata[CW-1:0];
        4'd6: a2_val  <= cfg_wdata[AW-1:0];
        4'd7: a2_msk  <= cfg_wdata[AW-1:0];
        4'd8: c2      <= cfg_wdata[12:0];
        4'd9: c3      <= cfg_wdata[12:0];
        default: ;
      endcase
    end
  end

  function automatic logic rw_en(input logic [1:0] s);
    return (s == 2'd1) || (s == 2'd2);
  endfunction

  function automatic logic rw_ok(input logic [1:0] s, input logic v, input logic w);
    return !rw_en(s) || (v && ((s == 2'd1) ? !w : w));
  endfunction

  function automatic logic view_ok(input logic en, input logic [1:0] s, input logic v,
                                   input logic dma, input logic fet, input logic hit);
    logic m;
    case (s)
      2'd0: m = !dma;
      2'd1: m = !dma && !fet;
      2'd2: m = dma || !hit;
      default: m = 1'b1;
    endcase
    return !en || (v && m);
  endfunction

  logic [DW-1:0] lane_m;
  logic          lsel;
  always_comb begin
    lane_m = '0;
    lsel   = 1'b0;
    for (int i = 0; i < NL; i++) begin
      case (bus_size)
        2'd0:    lsel = (bus_addr[LB-1:0] == i[LB-1:0]);
        2'd1:    lsel = (bus_addr[LB-1:1] == i[LB-1:1]);
        default: lsel = 1'b1;
      endcase
      if (lsel) lane_m[DW-1-8*i -: 8] = 8'hFF;
    end
  end

  logic a1_hit, d1_hit, s1_hit, raw1, fire1;
  assign a1_hit = (c1[1] ? pc_valid : bus_valid) &&
                  ((((c1[1] ? pc_value : bus_addr) ^ a1_val) & ~a1_msk) == '0);
  assign d1_hit = bus_valid && (((bus_data ^ d1_val) & ~d1_msk & lane_m) == '0);
  assign s1_hit = bus_valid && (bus_size == c1[5:4]);
  assign raw1 = c1[12] && (c1[0] || c1[2] || c1[3] || rw_en(c1[7:6]) || c1[10]) &&
                (!c1[0] || a1_hit) && (!c1[2] || d1_hit) && (!c1[3] || s1_hit) &&
                rw_ok(c1[7:6], bus_valid, bus_write) &&
                view_ok(c1[10], c1[9:8], bus_valid, bus_dma, bus_fetch, bus_cache_hit);
  assign fire1 = raw1 && (!c1[11] || ({1'b0, cnt} + 1'b1 >= {1'b0, cnt_lim}));

  logic a2_hit, fire2, fire3;
  assign a2_hit = (c2[1] ? pc_valid : bus_valid) &&
                  ((((c2[1] ? pc_value : bus_addr) ^ a2_val) & ~a2_msk) == '0);
  assign fire2 = c2[12] && (c2[0] || rw_en(c2[7:6]) || c2[10]) &&
                 (!c2[0] || a2_hit) && rw_ok(c2[7:6], bus_valid, bus_write) &&
                 view_ok(c2[10], c2[9:8], bus_valid, bus_dma, bus_fetch, bus_cache_hit);
  assign fire3 = c3[12] && (c3[0] || c3[1]) && (!c3[0] || io_access) && (!c3[1] || tlb_load);

  logic       clr_wr, restart;
  logic [2:0] clr_bits;
  assign clr_wr   = cfg_we && (cfg_addr == 4'd10);
  assign clr_bits = clr_wr ? cfg_wdata[2:0] : 3'b000;
  assign restart  = (cfg_we && (cfg_addr == 4'd5)) || clr_bits[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      brk_hit    <= '0;
      brk_status <= '0;
    end else begin
      if (restart)              cnt <= '0;
      else if (raw1 && c1[11])  cnt <= fire1 ? '0 : cnt + 1'b1;
      brk_hit    <= {fire3, fire2, fire1};
      brk_status <= (brk_status & ~clr_bits) | {fire3, fire2, fire1};
    end
  end

  assign brk_pulse = |brk_hit;
endmodule

// File: rtl/bus_break_checker.sv
module bus_break_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       brk_pulse,
  input logic [2:0] brk_hit,
  input logic [2:0] brk_status,
  input logic       bus_valid,
  input logic       pc_valid,
  input logic       io_access,
  input logic       tlb_load,
  input logic       cfg_we,
  input logic [3:0] cfg_addr,
  input logic [2:0] clr_data
);
  logic [2:0] keep;
  assign keep = brk_status & ~((cfg_we && cfg_addr == 4'd10) ? clr_data : 3'b000);

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (brk_status == 3'b000 && !brk_pulse));

  a_r9_hit_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_hit & ~brk_status) == 3'b000);

  a_r9_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((brk_status & $past(keep)) == $past(keep)));

  a_r2_ch1_needs_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    brk_hit[0] |-> $past(bus_valid || pc_valid));

  a_r7_ch2_needs_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    brk_hit[1] |-> $past(bus_valid || pc_valid));

  a_r8_ch3_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    brk_hit[2] |-> $past(io_access || tlb_load));
endmodule

bind bus_break_matcher bus_break_checker u_chk (
  .clk(clk), .rst_n(rst_n), .brk_pulse(brk_pulse), .brk_hit(brk_hit),
  .brk_status(brk_status), .bus_valid(bus_valid), .pc_valid(pc_valid),
  .io_access(io_access), .tlb_load(tlb_load), .cfg_we(cfg_we),
  .cfg_addr(cfg_addr), .clr_data(cfg_wdata[2:0])
);

// File: tb/sim_bus_break_matcher.sv
module sim_bus_break_matcher;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic        bus_valid = 0, bus_write = 0, bus_fetch = 0, bus_dma = 0, bus_cache_hit = 0;
  logic [31:0] bus_addr = 0, bus_data = 0, pc_value = 0, cfg_wdata = 0;
  logic [1:0]  bus_size = 0;
  logic        pc_valid = 0, io_access = 0, tlb_load = 0, cfg_we = 0;
  logic [3:0]  cfg_addr = 0;
  logic        brk_pulse;
  logic [2:0]  brk_hit, brk_status;

  bus_break_matcher u0 (.*);

  int checks = 0, fails = 0;
  logic done = 0;

  logic [31:0] m_a1, m_k1, m_a2, m_k2, m_d1, m_dk;
  logic [12:0] m_c1, m_c2, m_c3;
  logic [7:0]  m_lim, m_cnt;
  logic [2:0]  m_stat;

  task automatic model_reset();
    m_a1 = 0; m_k1 = 0; m_a2 = 0; m_k2 = 0; m_d1 = 0; m_dk = 0;
    m_c1 = 0; m_c2 = 0; m_c3 = 0; m_lim = 0; m_cnt = 0; m_stat = 0;
  endtask

  function automatic logic [31:0] lanes(input logic [1:0] sz, input logic [1:0] lo);
    if (sz == 0) return 32'hFF00_0000 >> (8 * lo);
    if (sz == 1) return lo[1] ? 32'h0000_FFFF : 32'hFFFF_0000;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic qual(input logic [12:0] c);
    logic r, v;
    r = 1;
    if (c[7:6] == 1) r = bus_valid && !bus_write;
    if (c[7:6] == 2) r = bus_valid && bus_write;
    case (c[9:8])
      0: v = !bus_dma;
      1: v = !bus_dma && !bus_fetch;
      2: v = bus_dma || !bus_cache_hit;
      default: v = 1;
    endcase
    if (c[10]) r = r && bus_valid && v;
    return r;
  endfunction

  function automatic logic addr_ok(input logic [12:0] c, input logic [31:0] a, input logic [31:0] k);
    logic [31:0] x;
    if (!c[0]) return 1;
    x = c[1] ? pc_value : bus_addr;
    return (c[1] ? pc_valid : bus_valid) && (((x ^ a) & ~k) == 0);
  endfunction

  function automatic logic raw1();
    logic any;
    any = m_c1[0] | m_c1[2] | m_c1[3] | m_c1[10] | (m_c1[7:6] == 1) | (m_c1[7:6] == 2);
    if (!m_c1[12] || !any) return 0;
    if (m_c1[2] && !(bus_valid && (((bus_data ^ m_d1) & ~m_dk & lanes(bus_size, bus_addr[1:0])) == 0))) return 0;
    if (m_c1[3] && !(bus_valid && bus_size == m_c1[5:4])) return 0;
    return addr_ok(m_c1, m_a1, m_k1) && qual(m_c1);
  endfunction

  function automatic logic fire2();
    logic any;
    any = m_c2[0] | m_c2[10] | (m_c2[7:6] == 1) | (m_c2[7:6] == 2);
    return m_c2[12] && any && addr_ok(m_c2, m_a2, m_k2) && qual(m_c2);
  endfunction

  function automatic logic fire3();
    return m_c3[12] && (m_c3[0] || m_c3[1]) && (!m_c3[0] || io_access) && (!m_c3[1] || tlb_load);
  endfunction

  task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: status/pulse/hit actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Inputs are set before this task is called, at a falling edge.
  task automatic step(input string tag);
    logic [2:0] f;
    logic r1;
    r1 = raw1();
    f[0] = r1 && (!m_c1[11] || ({1'b0, m_cnt} + 9'd1 >= {1'b0, m_lim}));
    f[1] = fire2();
    f[2] = fire3();
    if ((cfg_we && cfg_addr == 5) || (cfg_we && cfg_addr == 10 && cfg_wdata[0])) m_cnt = 0;
    else if (r1 && m_c1[11]) m_cnt = f[0] ? 8'd0 : m_cnt + 8'd1;
    m_stat = (m_stat & ~((cfg_we && cfg_addr == 10) ? cfg_wdata[2:0] : 3'b0)) | f;
    if (cfg_we) case (cfg_addr)
      0: m_a1 = cfg_wdata; 1: m_k1 = cfg_wdata; 2: m_d1 = cfg_wdata; 3: m_dk = cfg_wdata;
      4: m_c1 = cfg_wdata[12:0]; 5: m_lim = cfg_wdata[7:0]; 6: m_a2 = cfg_wdata;
      7: m_k2 = cfg_wdata; 8: m_c2 = cfg_wdata[12:0]; 9: m_c3 = cfg_wdata[12:0];
      default: ;
    endcase
    @(posedge clk); @(negedge clk);
    check(tag, {brk_status, brk_pulse, brk_hit}, {m_stat, |f, f});
  endtask

  task automatic idle();
    bus_valid = 0; pc_valid = 0; io_access = 0; tlb_load = 0; cfg_we = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
    idle(); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    step(tag);
    cfg_we = 0;
  endtask

  task automatic bus(input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz,
                     input logic w, input logic [2:0] kind, input string tag);
    idle(); bus_valid = 1; bus_addr = a; bus_data = d; bus_size = sz; bus_write = w;
    {bus_dma, bus_fetch, bus_cache_hit} = kind;
    step(tag);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check("R1", {brk_status, brk_pulse, brk_hit}, 7'b0);
    rst_n = 1;
    bus(32'h100, 0, 2, 0, 0, "R1");
    // R10: enabled, no sub-condition
    wr(4, 32'h1000, "R10");
    bus(32'h100, 0, 2, 0, 0, "R10");
    // R2: masked address
    wr(0, 32'h8000_1000, "R2"); wr(1, 32'h0000_000F, "R2");
    wr(4, 32'h1001, "R2");
    bus(32'h8000_100C, 0, 2, 0, 0, "R2");
    bus(32'h8000_1010, 0, 2, 0, 0, "R2");
    idle(); pc_valid = 1; pc_value = 32'h8000_1004; step("R2");
    wr(4, 32'h1003, "R2");
    idle(); pc_valid = 1; pc_value = 32'h8000_1004; step("R2");
    bus(32'h8000_1004, 0, 2, 0, 0, "R2");
    // R3: big-endian lanes
    wr(2, 32'h00AB_0000, "R3"); wr(3, 0, "R3"); wr(4, 32'h1004, "R3");
    bus(32'h1, 32'h11AB_2233, 0, 0, 0, "R3");
    bus(32'h2, 32'h11AB_2233, 0, 0, 0, "R3");
    bus(32'h0, 32'h00AB_FFFF, 1, 0, 0, "R3");
    bus(32'h2, 32'h00AB_FFFF, 1, 0, 0, "R3");
    bus(32'h0, 32'h00AB_0000, 2, 0, 0, "R3");
    bus(32'h0, 32'h00AB_0001, 2, 0, 0, "R3");
    wr(4, 32'h102C, "R3");
    bus(32'h0, 32'h00AB_0000, 2, 0, 0, "R3");
    bus(32'h0, 32'h00AB_0000, 1, 0, 0, "R3");
    // R4
    wr(4, 32'h1080, "R4");
    bus(32'h4, 0, 2, 1, 0, "R4"); bus(32'h4, 0, 2, 0, 0, "R4");
    wr(4, 32'h1040, "R4");
    bus(32'h4, 0, 2, 1, 0, "R4"); bus(32'h4, 0, 2, 0, 0, "R4");
    // R5: kind = {dma, fetch, cache_hit}
    for (int v = 0; v < 4; v++) begin
      wr(4, 32'h1400 | (v << 8), "R5");
      for (int k = 0; k < 8; k++) bus(32'h8, 0, 2, 0, k[2:0], "R5");
    end
    // R6: count of 3, restart on reload and clear
    wr(4, 32'h1C00 | (3 << 8), "R6"); wr(5, 3, "R6");
    for (int n = 0; n < 7; n++) bus(32'h8, 0, 2, 0, 0, "R6");
    wr(5, 3, "R6");
    bus(32'h8, 0, 2, 0, 0, "R6"); bus(32'h8, 0, 2, 0, 0, "R6");
    wr(10, 1, "R9");
    for (int n = 0; n < 3; n++) bus(32'h8, 0, 2, 0, 0, "R6");
    wr(5, 0, "R6");
    bus(32'h8, 0, 2, 0, 0, "R6");
    wr(4, 0, "R10");
    // R7: ch2 ignores data, size and ch1 data registers
    wr(6, 32'h40, "R7"); wr(7, 0, "R7"); wr(8, 32'h1081, "R7");
    wr(2, 32'h1234_5678, "R7");
    bus(32'h40, 32'hDEAD_BEEF, 0, 1, 0, "R7");
    bus(32'h40, 32'h0, 1, 1, 0, "R7");
    bus(32'h40, 32'h0, 1, 0, 0, "R7");
    bus(32'h44, 32'h0, 1, 1, 0, "R7");
    wr(8, 0, "R10");
    // R8
    wr(9, 32'h1001, "R8");
    idle(); io_access = 1; step("R8");
    idle(); tlb_load = 1; step("R8");
    wr(9, 32'h1003, "R8");
    idle(); io_access = 1; tlb_load = 1; step("R8");
    idle(); io_access = 1; step("R8");
    wr(9, 32'h0002, "R10");
    idle(); tlb_load = 1; step("R10");
    // R9: clear colliding with a hit, then plain clear
    wr(9, 32'h1002, "R9");
    idle(); tlb_load = 1; cfg_we = 1; cfg_addr = 10; cfg_wdata = 32'h7; step("R9");
    wr(10, 32'h7, "R9");
    wr(9, 0, "R9");
    // random phase
    void'($urandom(32'd20241));
    for (int blk = 0; blk < 40; blk++) begin
      wr(0, $urandom & 32'hFF0, "RND"); wr(1, $urandom & 32'h3, "RND");
      wr(2, $urandom, "RND"); wr(3, $urandom & $urandom, "RND");
      wr(6, $urandom & 32'hFF0, "RND"); wr(7, $urandom & 32'h7, "RND");
      wr(5, $urandom % 5, "RND");
      wr(4, $urandom & 32'h1FFF, "RND"); wr(8, $urandom & 32'h17C3, "RND");
      wr(9, $urandom & 32'h1003, "RND");
      for (int n = 0; n < 100; n++) begin
        idle();
        bus_valid = $urandom; bus_write = $urandom; bus_size = $urandom % 3;
        {bus_dma, bus_fetch, bus_cache_hit} = $urandom;
        bus_addr = ($urandom % 2) ? (m_a1 | ($urandom & 3)) : ($urandom % 2) ? m_a2 : ($urandom & 32'hFFF);
        bus_data = ($urandom % 2) ? m_d1 : $urandom;
        pc_valid = $urandom; pc_value = ($urandom % 2) ? m_a1 : m_a2;
        io_access = $urandom; tlb_load = $urandom;
        if ($urandom % 16 == 0) begin
          cfg_we = 1; cfg_addr = ($urandom % 2) ? 4'd10 : 4'd5; cfg_wdata = $urandom % 8;
        end
        step("RND");
      end
    end
    idle();
    finish_run();
  end
endmodule